// File: doc/BRIEF.md
# I2C Master Recovery Sequencer

This block brings an I2C master engine back to a known state after a transfer has gone wrong. An abort request arrives with two inputs: the status word that reported the fault and the port the transfer was using. The block then drives the engine through a fixed series of operations. It resets the engine and re-initialises it. If the port is not 0, it writes the port back. It clears the sticky busy flag of the port, runs the external bus-clear sequencer and clears the error latches. It then waits for the engine to settle. If command-complete is still low after that wait, the block resets and re-initialises the engine one more time and does not retry again.

Next the block looks at the status word. If the fault was a parity error, lost arbitration or a stop error, the block finishes at this point. Otherwise it sends a STOP command and polls command-complete until the STOP finishes or a time limit runs out.

Each operation goes to the engine as a one-cycle request carrying an operation code and a data word. The engine answers with an acknowledge, which carries a failure flag. All waits are timed from a clock-frequency parameter. A testbench can therefore shrink every duration by building the block with a small clock value.

Top module: `i2c_recovery_ctrl`

## Requirements
- R1: After `abort_i` is sampled high while idle, the block issues requests in this order: engine reset (op 0), engine init (op 1), port set (op 2), busy clear (op 3), bus clear (op 4), error clear (op 5). Each request is sent only after the previous one has been acknowledged without failure.
- R2: The port-set request carries the latched port number in the low bits of `data_o`. It is skipped entirely when that port number is 0.
- R3: The busy-clear request carries a data word with only bit 31 set (32'h8000_0000).
- R4: After the error-clear acknowledge, no request is issued and `done_o` stays low for 1.5 ms worth of clock cycles (CLK_KHZ*3/2). This wait lies between 1 ms and 2 ms.
- R5: If `cmd_comp_i` is low when the settle wait ends, the block issues exactly one more engine reset and engine init, and then goes on without another check.
- R6: If the latched status word has bit 0 (parity), bit 1 (lost arbitration) or bit 2 (stop error) set, the block finishes without issuing a STOP command.
- R7: Otherwise the block issues a STOP command (op 6) whose data has bit STOP_BIT (default 30) set. It then samples `cmd_comp_i` once every 100 µs (CLK_KHZ/10 cycles). It finishes without error at the first sample that sees the signal high.
- R8: If command-complete has not been seen 100 ms (CLK_KHZ*100 cycles) after the STOP acknowledge, the block finishes with `timeout_o` high.
- R9: An acknowledge with `fail_i` high ends the sequence at once. The block asserts `fail_o`, reports the failing op on `fail_op_o`, and issues no further request.
- R10: `req_o` and `done_o` are single-cycle pulses. Every abort ends with exactly one `done_o` pulse. `timeout_o` and `fail_o` are valid only together with `done_o` and are never both set.
- R11: After a synchronous reset, `req_o`, `done_o`, `timeout_o` and `fail_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Start a recovery when idle |
| abort_stat_i | input | STAT_W | Status word of the failed transfer |
| port_i | input | PORT_W | Port number of the failed transfer |
| cmd_comp_i | input | 1 | Command-complete status from the engine |
| ack_i | input | 1 | Engine acknowledge of the pending request |
| fail_i | input | 1 | Qualifies `ack_i`: the requested operation failed |
| req_o | output | 1 | One-cycle request strobe toward the engine |
| op_o | output | 3 | Operation code of the request |
| data_o | output | DATA_W | Data word of the request |
| done_o | output | 1 | One-cycle pulse at the end of every recovery |
| timeout_o | output | 1 | STOP completion timed out (with `done_o`) |
| fail_o | output | 1 | A step failed (with `done_o`) |
| fail_op_o | output | 3 | Op code of the failed step |

## Verification
The bench builds the block with CLK_KHZ set to 20. This shrinks the settle wait to 30 cycles, the poll interval to 2 cycles and the STOP time limit to 2000 cycles. With these values the timeout path and the single reset retry can be reached within a short run. The bounds on the settle wait and the time limit can then be measured exactly in cycles. A responder model acknowledges every request one cycle later. It can inject a failure on any chosen op code, which makes the early exit testable at each step.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  typedef enum logic [2:0] {
    OP_ENG_RST   = 3'd0,
    OP_ENG_INIT  = 3'd1,
    OP_PORT_SET  = 3'd2,
    OP_BUSY_CLR  = 3'd3,
    OP_BUS_CLEAR = 3'd4,
    OP_ERR_CLR   = 3'd5,
    OP_STOP      = 3'd6
  } rcv_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_SETTLE, S_DECIDE, S_POLL
  } rcv_state_e;

  // status word bits that suppress the final STOP
  localparam int PARITY_BIT  = 0;
  localparam int LOSTARB_BIT = 1;
  localparam int STOPERR_BIT = 2;
endpackage

// File: rtl/rcv_timer.sv
module rcv_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rcv_stop_gate.sv
module rcv_stop_gate import rcv_pkg::*; #(
  parameter int STAT_W = 8
) (
  input  logic [STAT_W-1:0] stat,
  output logic              skip_stop
);
  assign skip_stop = stat[PARITY_BIT] | stat[LOSTARB_BIT] | stat[STOPERR_BIT];
endmodule

// File: rtl/i2c_recovery_ctrl.sv
module i2c_recovery_ctrl import rcv_pkg::*; #(
  parameter int CLK_KHZ  = 50000,
  parameter int PORT_W   = 4,
  parameter int STAT_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STOP_BIT = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic [STAT_W-1:0] abort_stat_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              cmd_comp_i,
  input  logic              ack_i,
  input  logic              fail_i,
  output logic              req_o,
  output logic [2:0]        op_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              fail_o,
  output logic [2:0]        fail_op_o
);
  localparam int SETTLE_CYC = (CLK_KHZ * 3) / 2;
  localparam int POLL_CYC   = (CLK_KHZ / 10 > 0) ? CLK_KHZ / 10 : 1;
  localparam int TO_CYC     = CLK_KHZ * 100;
  localparam int TMR_W      = $clog2(TO_CYC + 1);
  localparam int POLL_W     = $clog2(POLL_CYC + 1);

  rcv_state_e        st, st_n;
  rcv_op_e           op_q, op_n;
  logic              retry_q, retry_n;
  logic [STAT_W-1:0] stat_q;
  logic [PORT_W-1:0] port_q;
  logic              issue, fin, fin_to, fin_fail;
  logic              mt_load, mt_exp, pt_load, pt_exp, skip_stop;
  logic [TMR_W-1:0]  mt_val;

  // one counter times both the settle wait and the STOP time limit
  rcv_timer #(.W(TMR_W)) u_main_tmr (
    .clk(clk), .rst(rst), .load(mt_load), .val(mt_val), .expired(mt_exp));

  rcv_timer #(.W(POLL_W)) u_poll_tmr (
    .clk(clk), .rst(rst), .load(pt_load), .val(POLL_W'(POLL_CYC)), .expired(pt_exp));

  rcv_stop_gate #(.STAT_W(STAT_W)) u_gate (.stat(stat_q), .skip_stop(skip_stop));

  always_comb begin
    st_n     = st;
    op_n     = op_q;
    retry_n  = retry_q;
    issue    = 1'b0;
    fin      = 1'b0;
    fin_to   = 1'b0;
    fin_fail = 1'b0;
    mt_load  = 1'b0;
    mt_val   = '0;
    pt_load  = 1'b0;
    case (st)
      S_IDLE: if (abort_i) begin
        op_n = OP_ENG_RST; retry_n = 1'b0; issue = 1'b1;
      end
      S_ISSUE: st_n = S_WAIT;
      S_WAIT: if (ack_i) begin
        if (fail_i) begin
          fin = 1'b1; fin_fail = 1'b1;
        end else begin
          case (op_q)
            OP_ENG_RST:   begin op_n = OP_ENG_INIT; issue = 1'b1; end
            OP_ENG_INIT:  if (retry_q) st_n = S_DECIDE;
                          else begin
                            op_n  = (port_q != '0) ? OP_PORT_SET : OP_BUSY_CLR;
                            issue = 1'b1;
                          end
            OP_PORT_SET:  begin op_n = OP_BUSY_CLR;  issue = 1'b1; end
            OP_BUSY_CLR:  begin op_n = OP_BUS_CLEAR; issue = 1'b1; end
            OP_BUS_CLEAR: begin op_n = OP_ERR_CLR;   issue = 1'b1; end
            OP_ERR_CLR:   begin
              st_n = S_SETTLE; mt_load = 1'b1; mt_val = TMR_W'(SETTLE_CYC);
            end
            OP_STOP:      begin
              st_n = S_POLL; mt_load = 1'b1; mt_val = TMR_W'(TO_CYC); pt_load = 1'b1;
            end
            default:      begin fin = 1'b1; fin_fail = 1'b1; end
          endcase
        end
      end
      S_SETTLE: if (mt_exp) begin
        if (cmd_comp_i) st_n = S_DECIDE;
        else begin
          retry_n = 1'b1; op_n = OP_ENG_RST; issue = 1'b1;
        end
      end
      S_DECIDE: if (skip_stop) fin = 1'b1;
                else begin op_n = OP_STOP; issue = 1'b1; end
      S_POLL: if (mt_exp) begin
        fin = 1'b1; fin_to = 1'b1;
      end else if (pt_exp) begin
        pt_load = 1'b1;
        if (cmd_comp_i) fin = 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
    if (issue) st_n = S_ISSUE;
    if (fin)   st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_ENG_RST;
      retry_q   <= 1'b0;
      stat_q    <= '0;
      port_q    <= '0;
      req_o     <= 1'b0;
      op_o      <= 3'd0;
      data_o    <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      fail_o    <= 1'b0;
      fail_op_o <= 3'd0;
    end else begin
      st        <= st_n;
      op_q      <= op_n;
      retry_q   <= retry_n;
      req_o     <= issue;
      done_o    <= fin;
      timeout_o <= fin_to;
      fail_o    <= fin_fail;
      if (fin_fail) fail_op_o <= op_q;
      if (st == S_IDLE && abort_i) begin
        stat_q <= abort_stat_i;
        port_q <= port_i;
      end
      if (issue) begin
        op_o <= op_n;
        case (op_n)
          OP_PORT_SET: data_o <= DATA_W'(port_q);
          OP_BUSY_CLR: data_o <= DATA_W'(1) << (DATA_W - 1);
          OP_STOP:     data_o <= DATA_W'(1) << STOP_BIT;
          default:     data_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rcv_checker.sv
module rcv_checker import rcv_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int STOP_BIT = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              req_o,
  input logic [2:0]        op_o,
  input logic [DATA_W-1:0] data_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              fail_o
);
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_no_req_at_done_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !req_o);
  p_port_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    (req_o && op_o == OP_PORT_SET) |-> (data_o != '0));
  p_busy_word_r3: assert property (@(posedge clk) disable iff (rst)
    (req_o && op_o == OP_BUSY_CLR) |-> (data_o == (DATA_W'(1) << (DATA_W - 1))));
  p_stop_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (req_o && op_o == OP_STOP) |-> data_o[STOP_BIT]);
  p_timeout_done_r8: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> done_o);
  p_fail_excl_r10: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (done_o && !timeout_o));
endmodule

bind i2c_recovery_ctrl rcv_checker #(.DATA_W(DATA_W), .STOP_BIT(STOP_BIT)) u_chk (
  .clk(clk), .rst(rst), .req_o(req_o), .op_o(op_o), .data_o(data_o),
  .done_o(done_o), .timeout_o(timeout_o), .fail_o(fail_o));

// File: tb/sim_i2c_recovery_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_recovery_ctrl;
  localparam int KHZ  = 20;
  localparam int POLL = KHZ / 10;
  localparam int TO   = KHZ * 100;

  logic clk = 1'b0, rst = 1'b1;
  logic abort_i = 1'b0, cmd_comp_i = 1'b0, ack_i = 1'b0, fail_i = 1'b0;
  logic [7:0] stat_i = '0;
  logic [3:0] port_i = '0;
  logic req_o, done_o, timeout_o, fail_o;
  logic [2:0] op_o, fail_op_o;
  logic [31:0] data_o;

  int checks = 0, errors = 0, cyc = 0;
  int n = 0, done_cnt = 0, done_cyc = 0;
  logic last_to, last_fail;
  logic [2:0] last_fop;
  logic fail_en = 1'b0;
  logic [2:0] fail_sel = 3'd0;
  int log_op [0:255];
  logic [31:0] log_dat [0:255];
  int log_cyc [0:255];

  always #10 clk = ~clk;

  i2c_recovery_ctrl #(.CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rst(rst), .abort_i(abort_i), .abort_stat_i(stat_i), .port_i(port_i),
    .cmd_comp_i(cmd_comp_i), .ack_i(ack_i), .fail_i(fail_i), .req_o(req_o), .op_o(op_o),
    .data_o(data_o), .done_o(done_o), .timeout_o(timeout_o), .fail_o(fail_o),
    .fail_op_o(fail_op_o));

  // engine responder: acknowledges each request one cycle later
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    ack_i  <= req_o;
    fail_i <= req_o && fail_en && (op_o == fail_sel);
    if (req_o) begin
      log_op[n & 255]  <= int'(op_o);
      log_dat[n & 255] <= data_o;
      log_cyc[n & 255] <= cyc;
      n <= n + 1;
    end
    if (done_o) begin
      done_cnt  <= done_cnt + 1;
      done_cyc  <= cyc;
      last_to   <= timeout_o;
      last_fail <= fail_o;
      last_fop  <= fail_op_o;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  endtask

  // start an abort and wait for done; returns index of first logged request
  task automatic run_abort(input logic [7:0] st, input logic [3:0] pt, output int base);
    int d0;
    @(negedge clk);
    base = n; d0 = done_cnt;
    stat_i = st; port_i = pt; abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    for (int w = 0; w < 5000 && done_cnt == d0; w++) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10", "one done per abort", done_cnt - d0, 1);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10", "done stays single", done_cnt - d0, 1);
  endtask

  task automatic chk_ops(input int base, input int exp_ops[], input string rq);
    chk(n - base == exp_ops.size(), rq, "request count", n - base, exp_ops.size());
    for (int i = 0; i < exp_ops.size() && i < n - base; i++)
      chk(log_op[(base + i) & 255] == exp_ops[i], rq, $sformatf("op at step %0d", i),
          log_op[(base + i) & 255], exp_ops[i]);
  endtask

  task automatic t_reset();
    chk(req_o == 1'b0 && done_o == 1'b0, "R11", "req/done after reset", int'({req_o, done_o}), 0);
    chk(timeout_o == 1'b0 && fail_o == 1'b0, "R11", "flags after reset", int'({timeout_o, fail_o}), 0);
  endtask

  task automatic t_normal();
    int b, gap;
    cmd_comp_i = 1'b1;
    run_abort(8'h00, 4'd3, b);
    chk_ops(b, '{0, 1, 2, 3, 4, 5, 6}, "R1");
    chk(log_dat[(b + 2) & 255] == 32'd3, "R2", "port data", int'(log_dat[(b + 2) & 255]), 3);
    chk(log_dat[(b + 3) & 255] == 32'h8000_0000, "R3", "busy clear data",
        int'(log_dat[(b + 3) & 255]), int'(32'h8000_0000));
    chk(log_dat[(b + 6) & 255] == 32'h4000_0000, "R7", "stop data",
        int'(log_dat[(b + 6) & 255]), int'(32'h4000_0000));
    gap = log_cyc[(b + 6) & 255] - log_cyc[(b + 5) & 255];
    chk(gap >= KHZ && gap <= 2 * KHZ + 6, "R4", "settle gap cycles", gap, KHZ * 3 / 2);
    chk(!last_to && !last_fail, "R7", "clean finish flags", int'({last_to, last_fail}), 0);
  endtask

  task automatic t_port0();
    int b;
    cmd_comp_i = 1'b1;
    run_abort(8'h00, 4'd0, b);
    chk_ops(b, '{0, 1, 3, 4, 5, 6}, "R2");
  endtask

  task automatic t_retry_skip();
    int b;
    cmd_comp_i = 1'b0;
    run_abort(8'h02, 4'd0, b);
    chk_ops(b, '{0, 1, 3, 4, 5, 0, 1}, "R5");
    chk(!last_to && !last_fail, "R6", "lost-arb finish flags", int'({last_to, last_fail}), 0);
    cmd_comp_i = 1'b1;
    run_abort(8'h01, 4'd0, b);
    chk_ops(b, '{0, 1, 3, 4, 5}, "R6");
    run_abort(8'h04, 4'd0, b);
    chk_ops(b, '{0, 1, 3, 4, 5}, "R6");
    run_abort(8'h08, 4'd0, b);
    chk_ops(b, '{0, 1, 3, 4, 5, 6}, "R6");
  endtask

  task automatic t_timeout();
    int b, gap;
    cmd_comp_i = 1'b0;
    run_abort(8'h00, 4'd0, b);
    chk_ops(b, '{0, 1, 3, 4, 5, 0, 1, 6}, "R8");
    chk(last_to == 1'b1 && last_fail == 1'b0, "R8", "timeout flag", int'({last_to, last_fail}), 2);
    gap = done_cyc - log_cyc[(b + 7) & 255];
    chk(gap >= TO && gap <= TO + 12, "R8", "stop-to-timeout cycles", gap, TO);
  endtask

  task automatic t_late_comp();
    int b, d0, rc;
    cmd_comp_i = 1'b0;
    @(negedge clk);
    b = n; d0 = done_cnt;
    stat_i = 8'h00; port_i = 4'd0; abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    for (int w = 0; w < 2000 && n < b + 8; w++) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(done_cnt == d0, "R7", "no finish before complete", done_cnt - d0, 0);
    cmd_comp_i = 1'b1; rc = cyc;
    for (int w = 0; w < 3000 && done_cnt == d0; w++) @(negedge clk);
    chk(done_cyc - rc <= POLL + 4 && done_cyc >= rc, "R7", "poll latency cycles", done_cyc - rc, POLL);
    chk(!last_to && !last_fail, "R7", "late finish flags", int'({last_to, last_fail}), 0);
  endtask

  task automatic t_fail();
    int b;
    cmd_comp_i = 1'b1;
    fail_en = 1'b1; fail_sel = 3'd3;
    run_abort(8'h00, 4'd5, b);
    chk_ops(b, '{0, 1, 2, 3}, "R9");
    chk(last_fail == 1'b1 && last_to == 1'b0, "R9", "fail flag", int'({last_fail, last_to}), 2);
    chk(last_fop == 3'd3, "R9", "failing op", int'(last_fop), 3);
    fail_sel = 3'd0;
    run_abort(8'h00, 4'd5, b);
    chk_ops(b, '{0}, "R9");
    chk(last_fop == 3'd0, "R9", "failing op reset", int'(last_fop), 0);
    fail_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_port0();
    t_retry_skip();
    t_timeout();
    t_late_comp();
    t_fail();
    finish_run();
  end
endmodule